// File: doc/BRIEF.md
# Timed IR Symbol Sequencer

This block plays a queue of infrared transmit symbols. Software writes 32-bit symbol words into a 128-entry FIFO. The sequencer pops them in order and turns each one into either a carrier-gated mark or a silent space. The length of a symbol is a count of ticks of a timebase that the word selects. Four free-running tick inputs are supplied from outside the block: 1 us, 10 us, 100 us and one carrier period. The carrier waveform itself also comes from outside, and the block only gates it onto the output.

A second write target holds the refill control: a level threshold, an interrupt enable and a sticky pending flag. The flag is raised when playback drains the FIFO down to the threshold. Software then tops the FIFO up with no more than depth minus threshold words and clears the flag. Symbols follow each other with no gap. When the queue runs dry, the output returns to its idle low level.

Top module: `ir_symbol_player`

## Requirements
- R1: After reset `fifo_level` is 0, and it always equals the number of queued words that have not been popped (0 to 128). A word is popped on the clock edge where it starts playing.
- R2: A write with `wr_sel`=0 queues `wr_data[12:0]` only when `wr_data[16]` is 1. Otherwise the FIFO is unchanged.
- R3: While a word with bit 12 set is playing, `ir_out` equals `carrier_in`. While a word with bit 12 clear is playing, `ir_out` is 0.
- R4: Bits [11:10] of a word pick its timebase tick: 0 selects `tick_1us`, 1 selects `tick_10us`, 2 selects `tick_100us` and 3 selects `tick_carrier`.
- R5: A word with bits [9:0] = N lasts N+1 ticks of its timebase. It ends at the edge where the (N+1)-th tick is seen after the edge that loaded it.
- R6: With nothing playing and the FIFO empty, `ir_out` is 0. A word in a FIFO that was empty at an edge is loaded at the following edge.
- R7: A queue write when `fifo_level` is 128 is dropped, and it sets `overflow`. `overflow` stays set until reset.
- R8: When a symbol ends and the FIFO is not empty, the next word is loaded on that same edge, with no idle cycle.
- R9: A write with `wr_sel`=1 loads the threshold from `wr_data[7:0]` and the enable from `wr_data[8]`. It clears the pending flag when `wr_data[16]` is 0 and leaves the flag unchanged when that bit is 1.
- R10: The pending flag sets on an edge where a pop with no accepted push brings the level down to the threshold. A set takes priority over a clear in the same cycle.
- R11: `irq` is the pending flag ANDed with the enable. Both are 0 after reset, and so is the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | 0 = symbol queue, 1 = refill control |
| wr_data | input | 32 | Write data |
| tick_1us | input | 1 | 1 us timebase pulse |
| tick_10us | input | 1 | 10 us timebase pulse |
| tick_100us | input | 1 | 100 us timebase pulse |
| tick_carrier | input | 1 | One pulse per carrier period |
| carrier_in | input | 1 | Carrier waveform |
| ir_out | output | 1 | Gated IR output |
| fifo_level | output | 8 | Number of queued words |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Refill interrupt |

## Verification
A wrong remaining-count or timebase select inside the sequencer shows at the ports within one tick of the affected timebase. `fifo_level` then drops one edge early or late, and `ir_out` stops following the carrier at the wrong time. An error in the FIFO pointers or the level counter shows on `fifo_level` at the very next edge. It shows on `ir_out` as soon as the corrupted word plays. A stray or missed pending set is visible on `irq` one edge after the level crosses the threshold, whenever the enable is set.

// File: rtl/ir_sym_pkg.sv
package ir_sym_pkg;

    localparam int SYM_DEPTH   = 128;
    localparam int DLY_W       = 10;
    localparam int STROBE_BIT  = 16;
    localparam int MARK_BIT    = 12;
    localparam int TB_LSB      = 10;
    localparam int CFG_EN_BIT  = 8;
    localparam int CFG_PND_BIT = 16;

    typedef enum logic [1:0] {
        TB_1US     = 2'd0,
        TB_10US    = 2'd1,
        TB_100US   = 2'd2,
        TB_CARRIER = 2'd3
    } tbase_e;

    typedef struct packed {
        logic             mark;
        tbase_e           tb;
        logic [DLY_W-1:0] dly;
    } sym_t;

    function automatic sym_t word_to_sym(input logic [31:0] w);
        sym_t s;
        s.mark = w[MARK_BIT];
        s.tb   = tbase_e'(w[TB_LSB+1:TB_LSB]);
        s.dly  = w[DLY_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo
    import ir_sym_pkg::*;
#(
    parameter int DEPTH = SYM_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  sym_t          din,
    input  logic          pop,
    output sym_t          dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_ok
);
    sym_t          mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R1
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1
                  || level + 1'b1 == $past(level)));

    // R1
    always_ff @(posedge clk) begin
        if (!rst) level_bound_chk: assert (level <= LW'(DEPTH));
    end

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> (level <= $past(level)));

endmodule

// File: rtl/ir_sym_seq.sv
module ir_sym_seq
    import ir_sym_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sym_t       head,
    input  logic       fifo_empty,
    input  logic [3:0] ticks,
    input  logic       carrier_in,
    output logic       pop,
    output logic       ir_out
);
    sym_t             cur_q;
    logic             active_q;
    logic [DLY_W-1:0] remain_q;
    logic             tick_sel;
    logic             last_tick;

    assign tick_sel  = ticks[cur_q.tb];
    assign last_tick = active_q && tick_sel && (remain_q == '0);
    assign pop       = (!active_q || last_tick) && !fifo_empty;
    assign ir_out    = active_q && cur_q.mark && carrier_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            remain_q <= '0;
        end else if (pop) begin
            active_q <= 1'b1;
            cur_q    <= head;
            remain_q <= head.dly;
        end else if (last_tick) begin
            active_q <= 1'b0;
        end else if (active_q && tick_sel) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // R5
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !tick_sel) |=> (active_q && $stable(remain_q)));

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (last_tick && !fifo_empty) |=> active_q);

endmodule

// File: rtl/ir_sym_irq.sv
module ir_sym_irq
    import ir_sym_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_data,
    input  logic [LW-1:0] level,
    input  logic          pop,
    input  logic          push_ok,
    output logic          irq
);
    logic [LW-1:0] thr_q;
    logic          en_q;
    logic          pend_q;
    logic          hit;

    assign hit = pop && !push_ok && ({1'b0, level} == {1'b0, thr_q} + 1'b1);
    assign irq = pend_q && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                thr_q <= cfg_data[LW-1:0];
                en_q  <= cfg_data[CFG_EN_BIT];
            end
            if (hit)
                pend_q <= 1'b1;
            else if (cfg_we && !cfg_data[CFG_PND_BIT])
                pend_q <= 1'b0;
        end
    end

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_q);

endmodule

// File: rtl/ir_symbol_player.sv
module ir_symbol_player
    import ir_sym_pkg::*;
#(
    parameter int DEPTH = SYM_DEPTH,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          tick_1us,
    input  logic          tick_10us,
    input  logic          tick_100us,
    input  logic          tick_carrier,
    input  logic          carrier_in,
    output logic          ir_out,
    output logic [LW-1:0] fifo_level,
    output logic          overflow,
    output logic          irq
);
    logic push_req, push_ok, pop, full, empty;
    sym_t head;
    logic [3:0] ticks;
    logic ovf_q;

    assign push_req = wr_en && !wr_sel && wr_data[STROBE_BIT];
    assign ticks    = {tick_carrier, tick_100us, tick_10us, tick_1us};
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (rst)                  ovf_q <= 1'b0;
        else if (push_req && full) ovf_q <= 1'b1;
    end

    ir_sym_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_req(push_req), .din(word_to_sym(wr_data)),
        .pop(pop), .dout(head), .level(fifo_level), .full(full),
        .empty(empty), .push_ok(push_ok)
    );

    ir_sym_seq u_seq (
        .clk(clk), .rst(rst), .head(head), .fifo_empty(empty), .ticks(ticks),
        .carrier_in(carrier_in), .pop(pop), .ir_out(ir_out)
    );

    ir_sym_irq #(.LW(LW)) u_irq (
        .clk(clk), .rst(rst), .cfg_we(wr_en && wr_sel), .cfg_data(wr_data),
        .level(fifo_level), .pop(pop), .push_ok(push_ok), .irq(irq)
    );

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: tb/ir_symbol_player_tb_top.sv
module ir_symbol_player_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick_1us = 0, tick_10us = 0, tick_100us = 0, tick_carrier = 0;
    logic        carrier_in = 0;
    logic        ir_out, overflow, irq;
    logic [7:0]  fifo_level;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    // bench reference state
    logic [12:0] q[$];
    bit          m_active, m_mark, m_pend, m_en, m_ovf;
    int          m_tb, m_rem, m_thr;

    always #5 clk = ~clk;

    ir_symbol_player dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_1us(tick_1us), .tick_10us(tick_10us), .tick_100us(tick_100us),
        .tick_carrier(tick_carrier), .carrier_in(carrier_in),
        .ir_out(ir_out), .fifo_level(fifo_level), .overflow(overflow), .irq(irq)
    );

    function automatic bit exp_ir(input bit act, input bit mk, input bit car);
        return act && mk && car;  // R3 R6
    endfunction

    function automatic bit tick_of(input int tb);
        case (tb)
            0:       return tick_1us;
            1:       return tick_10us;
            2:       return tick_100us;
            default: return tick_carrier;
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
        end
    endtask

    task automatic model_step();
        bit tsel, push_req, push_ok, load, hit;
        int lvl;
        logic [12:0] h;
        if (rst) begin
            q.delete();
            m_active = 0; m_mark = 0; m_pend = 0; m_en = 0; m_ovf = 0;
            m_tb = 0; m_rem = 0; m_thr = 0;
            return;
        end
        lvl      = q.size();
        tsel     = tick_of(m_tb);
        push_req = wr_en && !wr_sel && wr_data[16];         // R2
        push_ok  = push_req && (lvl < 128);                 // R7
        load     = (!m_active || (tsel && m_rem == 0)) && (lvl > 0);  // R6 R8
        hit      = load && !push_ok && (lvl - 1 == m_thr);  // R10
        if (wr_en && wr_sel) begin                          // R9
            m_thr = int'(wr_data[7:0]);
            m_en  = wr_data[8];
            if (!wr_data[16]) m_pend = 0;
        end
        if (hit) m_pend = 1;
        if (push_req && lvl == 128) m_ovf = 1;
        if (load) begin
            h = q.pop_front();
            m_active = 1; m_mark = h[12]; m_tb = int'(h[11:10]); m_rem = int'(h[9:0]);
        end else if (m_active && tsel) begin                // R4 R5
            if (m_rem == 0) m_active = 0;
            else            m_rem--;
        end
        if (push_ok) q.push_back(wr_data[12:0]);
    endtask

    task automatic cycle(input logic en, input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d;
        tick_1us     = (cyc % 3) == 0;
        tick_10us    = (cyc % 7) == 0;
        tick_100us   = (cyc % 11) == 0;
        tick_carrier = (cyc % 5) == 0;
        carrier_in   = (cyc / 2) % 2 == 1;
        #1;
        if (!rst) begin
            check("R1 R2 R7 level", int'(fifo_level), q.size());
            check("R3 R4 R5 R6 R8 ir_out", int'(ir_out), int'(exp_ir(m_active, m_mark, carrier_in)));
            check("R9 R10 R11 irq", int'(irq), int'(m_pend && m_en));
            check("R7 overflow", int'(overflow), int'(m_ovf));
        end
        @(posedge clk);
        model_step();
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);                                // reset state, R1 R11
        cycle(1'b1, 1'b0, 32'h0000_1005);       // R2: no strobe, dropped
        idle(4);
        cycle(1'b1, 1'b1, 32'h0000_0120);       // R9: thr 32, enable
        cycle(1'b1, 1'b0, 32'h0001_0BFF);       // long space, 100us x1024
        for (int i = 0; i < 130; i++)           // R7: fill past full
            cycle(1'b1, 1'b0, 32'h0001_1002);
        idle(11000);
        cycle(1'b1, 1'b1, 32'h0001_0120);       // R9: bit16 set keeps pending
        idle(1500);                             // R10: drain crosses 32
        cycle(1'b1, 1'b1, 32'h0001_0120);
        idle(4);
        cycle(1'b1, 1'b1, 32'h0000_0120);       // R9: clear pending
        idle(4);
        cycle(1'b1, 1'b0, 32'h0001_1C04);       // R3 R4 carrier-timed mark
        cycle(1'b1, 1'b0, 32'h0001_0405);       // R8 10us space after it
        cycle(1'b1, 1'b0, 32'h0001_1800);       // 100us mark, one unit
        idle(200);
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r, d;
            logic en, sel;
            r   = $urandom;
            en  = r[0] & r[1];
            sel = (r[6:2] == 5'd0);
            if (sel) begin
                d = {15'h0, r[7], 7'h0, r[8], 4'h0, 4'($urandom % 6)};
            end else begin
                d = $urandom;
                d[16] = (r[11:9] != 3'd0);
                d[9:0] = (r[15:12] == 4'd0) ? 10'($urandom % 40) : 10'($urandom % 4);
            end
            cycle(en, sel, d);
        end
        idle(2000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule